// File: doc/BRIEF.md
# Cascaded Master and Serial Clock Divider

This block derives two slower timing references from one master clock. A first stage divides the master clock by an integer ratio of 1 to 5, picked by a 3-bit code, and yields the internal clock. A second stage counts periods of that internal clock and divides it again by 1, 2, 4 or 8, picked by a 2-bit code, which yields the serial bit clock. Because the second stage advances only on internal clock periods, the serial period is the product of the two ratios in master clock cycles.

Both results are given as single-cycle enables in the master clock domain, plus a registered phase signal for each. Logic downstream can use the enables directly or use the phase as a duty-cycled level. A code change never cuts a running period short. Each stage finishes its current period with the old ratio and loads the new one at the period boundary.

Top module: `clkdiv_cascade`

## Requirements
- R1: Master code values 0, 1, 2, 3 and 4 give an internal enable that pulses once every 1, 2, 3, 4 and 5 master cycles respectively.
- R2: Master code values 5, 6 and 7 behave like code 0: the internal enable is high every master cycle.
- R3: Reset is released two master rising edges after `rst_ni` rises. The first stage starts at ratio 1, so the first internal enable is high in the cycle after that second edge. The second stage starts at ratio 8, so the first serial enable arrives with the eighth internal enable, whatever the codes are.
- R4: Serial code values 0, 1, 2 and 3 make the serial enable pulse once every 8, 4, 2 and 1 internal periods respectively.
- R5: With both codes steady, the serial enable period equals the product of the two ratios, measured in master cycles.
- R6: The internal phase is high for the first ceil(N/2) master cycles of each N-cycle internal period. The serial phase is high for the first N*ceil(M/2) master cycles of each serial period. Each phase rises in the cycle right after its enable.
- R7: A code change made in the middle of a period takes effect only after the current period of that stage has ended. No period is shortened or stretched beyond the old or the new length.
- R8: While reset is held, both enables stay low. The serial enable is only ever high in a cycle where the internal enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low reset; asserts at once, releases on the clock |
| mdiv_code_i | input | 3 | First-stage ratio code |
| sdiv_code_i | input | 2 | Second-stage ratio code |
| dclk_en_o | output | 1 | Internal clock enable, one master cycle per internal period |
| dclk_ph_o | output | 1 | Internal clock phase level |
| sclk_en_o | output | 1 | Serial clock enable, one master cycle per serial period |
| sclk_ph_o | output | 1 | Serial clock phase level |

## Verification
A corrupted count or latched ratio in the first stage shows as a wrong gap between internal enables. It appears no later than the next enable, at most five master cycles away. A fault in the second stage shows as a wrong serial period or phase length, at worst after eight internal periods, which is forty master cycles. A ratio loaded at the wrong moment shows in the one period that straddles a code change, which comes out with a length that is neither the old nor the new one. The bench therefore measures that straddling period explicitly for both stages.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int MCODE_W = 3;
  localparam int SCODE_W = 2;
  localparam int RATIO_W = 4;

  // First-stage code to ratio; unused codes fall back to pass-through.
  function automatic logic [RATIO_W-1:0] mdiv_ratio(input logic [MCODE_W-1:0] code);
    logic [RATIO_W-1:0] r;
    case (code)
      3'd0:    r = RATIO_W'(1);
      3'd1:    r = RATIO_W'(2);
      3'd2:    r = RATIO_W'(3);
      3'd3:    r = RATIO_W'(4);
      3'd4:    r = RATIO_W'(5);
      default: r = RATIO_W'(1);
    endcase
    return r;
  endfunction

  // Second-stage code to power-of-two ratio; code 0 is the slowest.
  function automatic logic [RATIO_W-1:0] sdiv_ratio(input logic [SCODE_W-1:0] code);
    logic [RATIO_W-1:0] r;
    case (code)
      2'd0:    r = RATIO_W'(8);
      2'd1:    r = RATIO_W'(4);
      2'd2:    r = RATIO_W'(2);
      default: r = RATIO_W'(1);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/clkdiv_stage.sv
module clkdiv_stage #(
  parameter int                 RATIO_W   = 4,
  parameter logic [RATIO_W-1:0] RST_RATIO = RATIO_W'(1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               tick_o,
  output logic               phase_o
);

  localparam int HALF_W = RATIO_W + 1;

  logic [RATIO_W-1:0] cnt_q, cnt_d;
  logic [RATIO_W-1:0] ratio_q, ratio_d;
  logic               phase_q, phase_d;
  logic               last_cnt;
  logic [HALF_W-1:0]  high_len;

  // Next-state: count enabled cycles, reload ratio only at period end.
  always_comb begin
    last_cnt = (cnt_q == ratio_q - RATIO_W'(1));
    tick_o   = en_i & last_cnt;
    cnt_d    = cnt_q;
    ratio_d  = ratio_q;
    if (tick_o) begin
      cnt_d   = '0;
      ratio_d = (ratio_i == '0) ? RATIO_W'(1) : ratio_i;
    end else if (en_i) begin
      cnt_d = cnt_q + RATIO_W'(1);
    end
    high_len = (HALF_W'(ratio_d) + HALF_W'(1)) >> 1;
    phase_d  = (HALF_W'(cnt_d) < high_len);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= RST_RATIO;
      phase_q <= 1'b1;
    end else if (en_i) begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      phase_q <= phase_d;
    end
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/clkdiv_cascade.sv
module clkdiv_cascade
  import clkdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MRST_RATIO  = 1,
  parameter int SRST_RATIO  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [MCODE_W-1:0] mdiv_code_i,
  input  logic [SCODE_W-1:0] sdiv_code_i,
  output logic               dclk_en_o,
  output logic               dclk_ph_o,
  output logic               sclk_en_o,
  output logic               sclk_ph_o
);

  logic               run_n;
  logic [RATIO_W-1:0] m_ratio;
  logic [RATIO_W-1:0] s_ratio;
  logic               d_tick, d_phase;
  logic               s_tick, s_phase;

  clkdiv_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (run_n)
  );

  always_comb begin
    m_ratio = mdiv_ratio(mdiv_code_i);
    s_ratio = sdiv_ratio(sdiv_code_i);
  end

  // First stage runs every master cycle once reset is released.
  clkdiv_stage #(
    .RATIO_W   (RATIO_W),
    .RST_RATIO (RATIO_W'(MRST_RATIO))
  ) u_mstage (
    .clk_i   (clk_i),
    .rst_ni  (run_n),
    .en_i    (run_n),
    .ratio_i (m_ratio),
    .tick_o  (d_tick),
    .phase_o (d_phase)
  );

  // Second stage advances once per internal period.
  clkdiv_stage #(
    .RATIO_W   (RATIO_W),
    .RST_RATIO (RATIO_W'(SRST_RATIO))
  ) u_sstage (
    .clk_i   (clk_i),
    .rst_ni  (run_n),
    .en_i    (d_tick),
    .ratio_i (s_ratio),
    .tick_o  (s_tick),
    .phase_o (s_phase)
  );

  assign dclk_en_o = d_tick;
  assign dclk_ph_o = d_phase;
  assign sclk_en_o = s_tick;
  assign sclk_ph_o = s_phase;

endmodule

// File: rtl/clkdiv_cascade_chk.sv
module clkdiv_cascade_chk
  import clkdiv_pkg::*;
#(
  parameter int MRST_RATIO = 1,
  parameter int SRST_RATIO = 8
) (
  input logic               clk_i,
  input logic               run_ni,
  input logic [MCODE_W-1:0] mdiv_code_i,
  input logic [SCODE_W-1:0] sdiv_code_i,
  input logic               dclk_en_o,
  input logic               dclk_ph_o,
  input logic               sclk_en_o,
  input logic               sclk_ph_o
);

  logic [RATIO_W-1:0] gap_q, mexp_q;
  logic [RATIO_W-1:0] tcnt_q, sexp_q;

  // Track cycles per internal period and the ratio due for it.
  always_ff @(posedge clk_i or negedge run_ni) begin
    if (!run_ni) begin
      gap_q  <= RATIO_W'(1);
      mexp_q <= RATIO_W'(MRST_RATIO);
    end else if (dclk_en_o) begin
      gap_q  <= RATIO_W'(1);
      mexp_q <= mdiv_ratio(mdiv_code_i);
    end else begin
      gap_q  <= gap_q + RATIO_W'(1);
    end
  end

  // Track internal periods per serial period.
  always_ff @(posedge clk_i or negedge run_ni) begin
    if (!run_ni) begin
      tcnt_q <= RATIO_W'(1);
      sexp_q <= RATIO_W'(SRST_RATIO);
    end else if (sclk_en_o) begin
      tcnt_q <= RATIO_W'(1);
      sexp_q <= sdiv_ratio(sdiv_code_i);
    end else if (dclk_en_o) begin
      tcnt_q <= tcnt_q + RATIO_W'(1);
    end
  end

  assert_dclk_period_R7: assert property (@(posedge clk_i) disable iff (!run_ni)
    dclk_en_o |-> (gap_q == mexp_q));

  assert_sclk_period_R7: assert property (@(posedge clk_i) disable iff (!run_ni)
    sclk_en_o |-> (tcnt_q == sexp_q));

  assert_sclk_inside_dclk_R8: assert property (@(posedge clk_i) disable iff (!run_ni)
    sclk_en_o |-> dclk_en_o);

  assert_dclk_phase_start_R6: assert property (@(posedge clk_i) disable iff (!run_ni)
    $rose(dclk_ph_o) |-> $past(dclk_en_o));

  assert_sclk_phase_start_R6: assert property (@(posedge clk_i) disable iff (!run_ni)
    $rose(sclk_ph_o) |-> $past(sclk_en_o));

  always @(posedge clk_i) begin
    if (!run_ni) begin
      assert_quiet_in_reset_R8: assert (!dclk_en_o && !sclk_en_o);
    end
  end

endmodule

bind clkdiv_cascade clkdiv_cascade_chk #(
  .MRST_RATIO (MRST_RATIO),
  .SRST_RATIO (SRST_RATIO)
) u_chk (
  .clk_i       (clk_i),
  .run_ni      (run_n),
  .mdiv_code_i (mdiv_code_i),
  .sdiv_code_i (sdiv_code_i),
  .dclk_en_o   (dclk_en_o),
  .dclk_ph_o   (dclk_ph_o),
  .sclk_en_o   (sclk_en_o),
  .sclk_ph_o   (sclk_ph_o)
);

// File: tb/clkdiv_cascade_tb.sv
module clkdiv_cascade_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 150000;

  typedef struct {
    int    val;
    string tag;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic [2:0] mcode;
  logic [1:0] scode;
  logic       dclk_en, dclk_ph, sclk_en, sclk_ph;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  exp_t dq_per[$];
  exp_t dq_hi[$];
  exp_t sq_per[$];
  exp_t sq_hi[$];

  clkdiv_cascade u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mdiv_code_i (mcode),
    .sdiv_code_i (scode),
    .dclk_en_o   (dclk_en),
    .dclk_ph_o   (dclk_ph),
    .sclk_en_o   (sclk_en),
    .sclk_ph_o   (sclk_ph)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_m(input int code);
    return (code <= 4) ? code + 1 : 1;
  endfunction

  function automatic int exp_s(input int code);
    return 8 >> code;
  endfunction

  // Monitor: measure periods and high times at negedges, pop and compare.
  initial begin
    int dgap = 0, dhi = 0, sgap = 0, shi = 0;
    exp_t it;
    forever begin
      @(negedge clk);
      dgap++; dhi += int'(dclk_ph);
      sgap++; shi += int'(sclk_ph);
      if (dclk_en) begin
        if (dq_per.size() > 0) begin it = dq_per.pop_front(); check(it.tag, dgap, it.val); end
        if (dq_hi.size() > 0)  begin it = dq_hi.pop_front();  check(it.tag, dhi, it.val);  end
        dgap = 0; dhi = 0;
      end
      if (sclk_en) begin
        if (sq_per.size() > 0) begin it = sq_per.pop_front(); check(it.tag, sgap, it.val); end
        if (sq_hi.size() > 0)  begin it = sq_hi.pop_front();  check(it.tag, shi, it.val);  end
        sgap = 0; shi = 0;
      end
    end
  end

  task automatic wait_sclk();
    do @(negedge clk); while (!sclk_en);
  endtask

  task automatic wait_dclk();
    do @(negedge clk); while (!dclk_en);
  endtask

  task automatic drain();
    while (dq_per.size() + dq_hi.size() + sq_per.size() + sq_hi.size() > 0)
      @(negedge clk);
  endtask

  // Driver: apply codes, settle, push expected items for one config.
  task automatic run_cfg(input int mc, input int sc);
    int n = exp_m(mc);
    int m = exp_s(sc);
    string dtag = (mc <= 4) ? "R1" : "R2";
    @(negedge clk);
    mcode = 3'(mc);
    scode = 2'(sc);
    wait_sclk();
    wait_sclk();
    @(posedge clk);
    dq_per.push_back('{n, dtag});
    dq_hi.push_back('{(n + 1) / 2, "R6"});
    sq_per.push_back('{n * m, "R4,R5"});
    sq_hi.push_back('{n * ((m + 1) / 2), "R6"});
    drain();
  endtask

  initial begin
    int k;
    int ticks;
    rst_n = 1'b0;
    mcode = 3'd1;
    scode = 2'd3;
    repeat (5) @(negedge clk);
    check("R8 dclk_en in reset", int'(dclk_en), 0);
    check("R8 sclk_en in reset", int'(sclk_en), 0);
    rst_n = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!dclk_en && k < 20);
    check("R3 first internal enable cycle", k, 2);
    ticks = 1;
    while (!sclk_en && ticks < 40) begin
      wait_dclk();
      ticks++;
    end
    check("R3 internal enables up to first serial", ticks, 8);

    for (int mc = 0; mc < 8; mc++)
      for (int sc = 0; sc < 4; sc++)
        run_cfg(mc, sc);

    // R7: first stage, long to short, change mid-period.
    run_cfg(4, 3);
    wait_dclk();
    @(posedge clk);
    dq_per.push_back('{5, "R7"});
    dq_per.push_back('{1, "R7"});
    @(negedge clk); @(negedge clk);
    mcode = 3'd0;
    drain();

    // R7: first stage, short to long, change right after an enable.
    wait_dclk();
    @(posedge clk);
    dq_per.push_back('{1, "R7"});
    dq_per.push_back('{5, "R7"});
    @(negedge clk);
    mcode = 3'd4;
    drain();

    // R7: second stage, slow to fast, change mid-period.
    run_cfg(0, 0);
    wait_sclk();
    @(posedge clk);
    sq_per.push_back('{8, "R7"});
    sq_per.push_back('{1, "R7"});
    repeat (3) @(negedge clk);
    scode = 2'd3;
    drain();

    // R8: serial enable only with internal enable, under a cascaded ratio.
    @(negedge clk);
    mcode = 3'd2;
    scode = 2'd2;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (sclk_en) check("R8 serial needs internal", int'(dclk_en), 1);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R1: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule